// File: doc/BRIEF.md
# Two-Channel Interrupt Status and Enable Unit

This block gathers the transmit-ready and receive-ready levels of two serial channels into one shared status word and combines it with a software-loaded enable word to drive a single active-low interrupt request. Both words live at one global register address. A read there returns the live status. A write there loads the enable word.

Software reaches registers through a channel-relative address, which is a channel index plus a local offset. The block turns that pair into a global address in which each channel has its own window of eight bytes. It drives the global address out registered, so that neighbouring channel logic can decode it. Only the shared status/enable address is served here; every other address reads as zero.

Each channel owns one four-bit nibble of the status and enable words. Transmit-ready sits in the lowest bit of the nibble, receive-ready in the next bit, and the two upper bits are always zero.

Top module: `irq_hub_top`

## Requirements
- R1: After every clock edge, `glob_addr` holds channel index × 8 + local offset, taken from `bus_chan` and `bus_off` at that edge.
- R2: The status/enable register answers only at global address 0x05. A write to any other global address leaves the enable word unchanged. A read from any other address, or a cycle with no read, gives `rd_data` = 0 after the edge.
- R3: A read at global address 0x05 puts the status sampled at that edge on `rd_data` after the edge. Bit 4n is the transmit-ready level of channel n and bit 4n+1 is its receive-ready level.
- R4: Bits 2, 3, 6 and 7 of the status always read as zero. The enable word stores those bit positions as zero, so they can never raise the interrupt.
- R5: A write at global address 0x05 loads `wr_data` into the enable word. After each edge, `irq_n` is low exactly when some status bit sampled at that edge is set and its enable bit is set, using the enable value that results from a write taken at that same edge.
- R6: Status bits are live levels. When the last enabled ready input drops, `irq_n` returns high at the next edge and a read shows the bit cleared.
- R7: While the enable word is zero, `irq_n` stays high whatever the ready inputs do.
- R8: A synchronous reset clears the enable word, `rd_data` and `glob_addr`, and drives `irq_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_rdy | input | 2 | Transmit-ready level per channel |
| rx_rdy | input | 2 | Receive-ready level per channel |
| bus_chan | input | 1 | Channel index of the access |
| bus_off | input | 3 | Local register offset within the channel window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| glob_addr | output | 4 | Registered global address |
| irq_n | output | 1 | Active-low interrupt request, registered |

## Verification
On every cycle, the assertions check the relation between the interrupt output, the sampled status and the enable word. They also check that the enable bits in the unused positions stay zero, that a zero enable word keeps the request high, that a read captures the status, that a write loads the enable word, and how the global address is formed. Only the bench's directed scenarios show other points from the ports. These are that the bit positions match the intended channel and direction, that a write to the other channel's window has no effect, and that the request drops as soon as a ready input clears or the enable word is zeroed.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int NIB_W   = 4;
  localparam int TX_BIT  = 0;
  localparam int RX_BIT  = 1;

  // Bits that carry a ready level in a word serving nch channels
  function automatic logic [63:0] live_bits(input int nch);
    logic [63:0] v;
    v = '0;
    for (int c = 0; c < nch; c++) begin
      v[c*NIB_W + TX_BIT] = 1'b1;
      v[c*NIB_W + RX_BIT] = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/irq_hub_addr.sv
module irq_hub_addr #(
  parameter int CH_W   = 1,
  parameter int OFF_W  = 3,
  parameter int GA_W   = CH_W + OFF_W,
  parameter logic [GA_W-1:0] SEL_ADDR = GA_W'(5)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CH_W-1:0] chan,
  input  logic [OFF_W-1:0] off,
  output logic            sel,
  output logic [GA_W-1:0] gaddr_q
);
  logic [GA_W-1:0] gaddr_c;

  always_comb begin
    gaddr_c = (GA_W'(chan) << OFF_W) + GA_W'(off);
    sel     = (gaddr_c == SEL_ADDR);
  end

  always_ff @(posedge clk) begin
    if (rst) gaddr_q <= '0;
    else     gaddr_q <= gaddr_c;
  end
endmodule

// File: rtl/irq_hub_pack.sv
module irq_hub_pack
  import irq_hub_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DW     = NUM_CH * NIB_W
) (
  input  logic [NUM_CH-1:0] tx,
  input  logic [NUM_CH-1:0] rx,
  output logic [DW-1:0]     stat
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_nib
    always_comb begin
      stat[c*NIB_W +: NIB_W]  = '0;
      stat[c*NIB_W + TX_BIT]  = tx[c];
      stat[c*NIB_W + RX_BIT]  = rx[c];
    end
  end
endmodule

// File: rtl/irq_hub_mask.sv
module irq_hub_mask
  import irq_hub_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DW     = NUM_CH * NIB_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] stat,
  output logic [DW-1:0] mask_q,
  output logic          irq_n_q
);
  localparam logic [63:0]   LIVE64 = live_bits(NUM_CH);
  localparam logic [DW-1:0] LIVE   = LIVE64[DW-1:0];

  logic [DW-1:0] mask_d;

  always_comb begin
    mask_d = load ? (din & LIVE) : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      irq_n_q <= 1'b1;
    end else begin
      mask_q  <= mask_d;
      irq_n_q <= ~|(stat & mask_d);
    end
  end
endmodule

// File: rtl/irq_hub_top.sv
module irq_hub_top
  import irq_hub_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int OFF_W    = 3,
  parameter int SEL_GADR = 5,
  parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int GA_W     = CH_W + OFF_W,
  parameter int DW       = NUM_CH * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] tx_rdy,
  input  logic [NUM_CH-1:0] rx_rdy,
  input  logic [CH_W-1:0]   bus_chan,
  input  logic [OFF_W-1:0]  bus_off,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  output logic [GA_W-1:0]   glob_addr,
  output logic              irq_n
);
  logic          sel_w;
  logic [DW-1:0] stat_w;
  logic [DW-1:0] mask_w;

  irq_hub_addr #(.CH_W(CH_W), .OFF_W(OFF_W), .GA_W(GA_W),
                 .SEL_ADDR(GA_W'(SEL_GADR))) u_addr (
    .clk(clk), .rst(rst), .chan(bus_chan), .off(bus_off),
    .sel(sel_w), .gaddr_q(glob_addr)
  );

  irq_hub_pack #(.NUM_CH(NUM_CH), .DW(DW)) u_pack (
    .tx(tx_rdy), .rx(rx_rdy), .stat(stat_w)
  );

  irq_hub_mask #(.NUM_CH(NUM_CH), .DW(DW)) u_mask (
    .clk(clk), .rst(rst), .load(bus_wr & sel_w), .din(wr_data),
    .stat(stat_w), .mask_q(mask_w), .irq_n_q(irq_n)
  );

  always_ff @(posedge clk) begin
    if (rst)                  rd_data <= '0;
    else if (bus_rd && sel_w) rd_data <= stat_w;
    else                      rd_data <= '0;
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int DW   = 8,
  parameter int CH_W = 1,
  parameter int OFF_W = 3,
  parameter int GA_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [DW-1:0]   stat,
  input logic [DW-1:0]   mask,
  input logic            sel,
  input logic            rd,
  input logic            wr,
  input logic [DW-1:0]   wdata,
  input logic [DW-1:0]   rdata,
  input logic [CH_W-1:0] chan,
  input logic [OFF_W-1:0] off,
  input logic [GA_W-1:0] gaddr,
  input logic            irq_n
);
  localparam logic [63:0]   LIVE64 = irq_hub_pkg::live_bits(DW / irq_hub_pkg::NIB_W);
  localparam logic [DW-1:0] LIVE   = LIVE64[DW-1:0];

  a_r1_gaddr: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> gaddr == (GA_W'($past(chan)) << OFF_W) + GA_W'($past(off)));

  a_r3_read_status: assert property (@(posedge clk) disable iff (rst)
    (rd && sel) |=> rdata == $past(stat));

  a_r4_unused_mask: assert property (@(posedge clk) disable iff (rst)
    (mask & ~LIVE) == '0);

  a_r5_irq_level: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_n == ~|($past(stat) & mask));

  a_r5_mask_load: assert property (@(posedge clk) disable iff (rst)
    (wr && sel) |=> mask == ($past(wdata) & LIVE));

  a_r2_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr && sel) |=> $stable(mask));

  a_r7_zero_mask: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |-> irq_n);
endmodule

bind irq_hub_top irq_hub_chk #(.DW(DW), .CH_W(CH_W), .OFF_W(OFF_W), .GA_W(GA_W)) u_chk (
  .clk(clk), .rst(rst), .stat(stat_w), .mask(mask_w), .sel(sel_w),
  .rd(bus_rd), .wr(bus_wr), .wdata(wr_data), .rdata(rd_data),
  .chan(bus_chan), .off(bus_off), .gaddr(glob_addr), .irq_n(irq_n)
);

// File: tb/irq_hub_top_bench.sv
module irq_hub_top_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] tx_rdy, rx_rdy;
  logic       bus_chan;
  logic [2:0] bus_off;
  logic       bus_rd, bus_wr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [3:0] glob_addr;
  logic       irq_n;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_hub_top u_irq_hub_top (
    .clk(clk), .rst(rst), .tx_rdy(tx_rdy), .rx_rdy(rx_rdy),
    .bus_chan(bus_chan), .bus_off(bus_off), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .wr_data(wr_data), .rd_data(rd_data), .glob_addr(glob_addr), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_stat(input logic [1:0] t, input logic [1:0] r);
    logic [7:0] s = '0;
    for (int c = 0; c < 2; c++) begin
      s[4*c]     = t[c];
      s[4*c + 1] = r[c];
    end
    return s;
  endfunction

  // One bus access; sampled 1 ns after the edge that takes it
  task automatic access(input logic ch, input logic [2:0] off,
                        input logic rd, input logic wr, input logic [7:0] wd);
    @(negedge clk);
    bus_chan = ch; bus_off = off; bus_rd = rd; bus_wr = wr; wr_data = wd;
    @(posedge clk); #1;
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic set_rdy(input logic [1:0] t, input logic [1:0] r);
    @(negedge clk);
    tx_rdy = t; rx_rdy = r;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R8 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R8 rd_data", rd_data, 8'h00);
    chk("R8 glob_addr", {4'd0, glob_addr}, 8'h00);
  endtask

  task automatic t_addr();
    access(1'b1, 3'd3, 1'b0, 1'b0, 8'h00);
    chk("R1 ch1 off3", {4'd0, glob_addr}, 8'h0B);
    access(1'b0, 3'd5, 1'b0, 1'b0, 8'h00);
    chk("R1 ch0 off5", {4'd0, glob_addr}, 8'h05);
  endtask

  task automatic t_status();
    set_rdy(2'b01, 2'b10);
    access(1'b0, 3'd5, 1'b1, 1'b0, 8'h00);
    chk("R3 tx0 rx1", rd_data, exp_stat(2'b01, 2'b10));
    set_rdy(2'b11, 2'b11);
    access(1'b0, 3'd5, 1'b1, 1'b0, 8'h00);
    chk("R4 all set reads 33", rd_data, 8'h33);
    access(1'b1, 3'd5, 1'b1, 1'b0, 8'h00);
    chk("R2 read other window", rd_data, 8'h00);
  endtask

  task automatic t_irq();
    set_rdy(2'b01, 2'b00);
    access(1'b0, 3'd5, 1'b0, 1'b1, 8'h01);
    chk("R5 tx0 enabled", {7'd0, irq_n}, 8'h00);
    access(1'b0, 3'd5, 1'b0, 1'b1, 8'h20);
    chk("R5 rx1 enabled, only tx0", {7'd0, irq_n}, 8'h01);
    set_rdy(2'b01, 2'b10);
    chk("R5 rx1 rises", {7'd0, irq_n}, 8'h00);
  endtask

  task automatic t_live();
    set_rdy(2'b01, 2'b00);
    chk("R6 rx1 clears", {7'd0, irq_n}, 8'h01);
    access(1'b0, 3'd5, 1'b1, 1'b0, 8'h00);
    chk("R6 status cleared", rd_data, 8'h01);
  endtask

  task automatic t_zero();
    set_rdy(2'b11, 2'b11);
    access(1'b0, 3'd5, 1'b0, 1'b1, 8'h33);
    chk("R5 all enabled", {7'd0, irq_n}, 8'h00);
    access(1'b0, 3'd5, 1'b0, 1'b1, 8'h00);
    chk("R7 zero mask", {7'd0, irq_n}, 8'h01);
    set_rdy(2'b10, 2'b01);
    chk("R7 inputs toggle", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_ignore();
    set_rdy(2'b11, 2'b11);
    access(1'b1, 3'd5, 1'b0, 1'b1, 8'hFF);
    chk("R2 write 0x0D ignored", {7'd0, irq_n}, 8'h01);
    access(1'b0, 3'd4, 1'b0, 1'b1, 8'hFF);
    chk("R2 write 0x04 ignored", {7'd0, irq_n}, 8'h01);
    access(1'b0, 3'd5, 1'b0, 1'b1, 8'hCC);
    chk("R4 unused enable bits", {7'd0, irq_n}, 8'h01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; tx_rdy = '0; rx_rdy = '0;
    bus_chan = 1'b0; bus_off = '0; bus_rd = 1'b0; bus_wr = 1'b0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst = 1'b0;
    t_addr();
    t_status();
    t_irq();
    t_live();
    t_zero();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule